// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block produces the digital clock and gate sequence for a two-phase linear CCD sensor that has two transfer gates. It runs from a single fast clock; every CCD element period is `TPE` ticks of that clock, so edges inside an element can be placed to one tick. Each line starts with a transfer period that moves charge from the photodiodes into the CCD. A readout period follows, in which the block drives the two shift phases, a reset pulse, and clamp and sample strobes for correlated double sampling.

The block also tells downstream capture logic what each pixel is. On every sample strobe it presents a 2-bit region code (blank, dark or active), which depends on the pixel's position in the line. It also raises a line-start flag on the first sample of each line. The line length and the phase dead time are programmable, and new values take effect only at a line boundary. The interface is plain control pins. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is asserted, and until the first line begins, every strobe output is low and `region_o` is 00.
- R2: A line lasts L elements of `TPE` ticks, where L is the value of `line_len_i` latched at the line boundary. A value below `XFER`+1 (9 by default) is treated as `XFER`+1. The first `XFER` (8) elements form the transfer period and the rest form the readout.
- R3: Both transfer gates rise at the start of the line. Gate 1 stays high for `XFER`-2 elements. Gate 2 falls exactly one element after gate 1. The first reset pulse of the readout comes exactly one element after gate 2 falls.
- R4: While gate 2 is high, phase 1 is held high and phase 2 is held low.
- R5: A line length or dead time written in the middle of a line does not change that line. It applies from the next line.
- R6: In readout element ticks 0..`TPE`-1 with dead time d, phase 2 is high for ticks d to `TPE`/2-1 and phase 1 is high for ticks `TPE`/2+d to `TPE`-1. Phase 1 and phase 2 are never high at the same time, and each gap between them lasts d ticks.
- R7: A dead time of 0 is used as 1, and a dead time above `TPE`/2-1 is used as `TPE`/2-1.
- R8: The reset pulse is one tick long at the start of each readout element. The sample strobe comes in the tick just before the reset pulse. The clamp strobe comes in the first tick after phase 2 falls.
- R9: `region_o` updates with each sample strobe. Its codes are 00 for blank, 01 for dark and 10 for active. Counting samples from the start of readout, the order is 4 blank, 12 dark, 2098 active and 12 dark, and every later sample is blank.
- R10: The first dark sample is the one that follows the fifth falling edge of phase 2 in the readout.
- R11: `line_start_o` is high for exactly one tick per line, together with the first sample strobe of the readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, `TPE` ticks per CCD element |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_len_i | input | LEN_W | Line length in elements, latched at line boundary |
| dead_i | input | DT_W | Phase dead time in ticks, latched at line boundary |
| phi1_o | output | 1 | Shift phase 1 |
| phi2_o | output | 1 | Shift phase 2 |
| tg1_o | output | 1 | Transfer gate 1 |
| tg2_o | output | 1 | Transfer gate 2 |
| rst_pulse_o | output | 1 | Output-node reset pulse |
| clamp_o | output | 1 | CDS clamp strobe |
| sample_o | output | 1 | CDS sample strobe |
| line_start_o | output | 1 | First-pixel flag, coincident with sample |
| region_o | output | 2 | Pixel region code of the current sample |

## Verification
If the element counter or the latched length is wrong, the spacing between rising edges of transfer gate 1 is wrong by whole elements within one line. If the gate ordering is wrong, the gate 1 to gate 2 delay and the gate 2 to reset delay differ from one element on the very first line. An error in the tick counter or the dead-time clamp shows within one readout element as wrong phase widths or wrong gaps, or as a reset, clamp or sample strobe moved by one tick. A wrong readout index or wrong segment limits show within one line as shifted region counts, as a first dark sample that does not follow the fifth phase 2 fall, or as a misplaced line-start flag.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic [1:0] {
    RGN_BLANK  = 2'd0,
    RGN_DARK   = 2'd1,
    RGN_ACTIVE = 2'd2
  } region_e;
endpackage

// File: rtl/lct_tick_gen.sv
// Sub-element tick counter: TPE ticks form one CCD element.
module lct_tick_gen #(
  parameter int TPE = 8,
  parameter int TW  = $clog2(TPE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [TW-1:0] tick_o,
  output logic          last_o
);
  assign last_o = (tick_o == TW'(TPE - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     tick_o <= '0;
    else if (last_o) tick_o <= '0;
    else             tick_o <= tick_o + 1'b1;
  end
endmodule

// File: rtl/lct_line_seq.sv
// Element counter per line; latches length and dead time at each line boundary.
module lct_line_seq #(
  parameter int LEN_W = 16,
  parameter int XFER  = 8,
  parameter int DT_W  = 3,
  parameter int HALF  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             elem_last_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             run_o,
  output logic [LEN_W-1:0] elem_o,
  output logic             xfer_o,
  output logic [LEN_W-1:0] rd_idx_o,
  output logic [DT_W-1:0]  dead_o
);
  localparam int MIN_LINE = XFER + 1;

  logic [LEN_W-1:0] len_q, len_nxt;
  logic [DT_W-1:0]  dead_nxt;
  logic             wrap;

  assign wrap     = elem_last_i && (elem_o == len_q - 1'b1);
  assign xfer_o   = (elem_o < LEN_W'(XFER));
  assign rd_idx_o = elem_o - LEN_W'(XFER);

  always_comb begin
    len_nxt = (len_i < LEN_W'(MIN_LINE)) ? LEN_W'(MIN_LINE) : len_i;
    if (dead_i == '0)                      dead_nxt = DT_W'(1);
    else if (dead_i > DT_W'(HALF - 1))     dead_nxt = DT_W'(HALF - 1);
    else                                   dead_nxt = dead_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      elem_o <= LEN_W'(MIN_LINE - 1);
      len_q  <= LEN_W'(MIN_LINE);
      dead_o <= DT_W'(1);
      run_o  <= 1'b0;
    end else if (wrap) begin
      elem_o <= '0;
      len_q  <= len_nxt;
      dead_o <= dead_nxt;
      run_o  <= 1'b1;
    end else if (elem_last_i) begin
      elem_o <= elem_o + 1'b1;
    end
  end
endmodule

// File: rtl/lct_region_map.sv
// Maps a readout element index to its pixel region.
module lct_region_map import lct_pkg::*; #(
  parameter int LEN_W      = 16,
  parameter int LEAD_BLANK = 4,
  parameter int LEAD_DARK  = 12,
  parameter int ACTIVE     = 2098,
  parameter int TRAIL_DARK = 12
) (
  input  logic [LEN_W-1:0] idx_i,
  output region_e          region_o
);
  localparam int E_DARK0  = LEAD_BLANK;
  localparam int E_ACT    = E_DARK0 + LEAD_DARK;
  localparam int E_DARK1  = E_ACT + ACTIVE;
  localparam int E_BLANK1 = E_DARK1 + TRAIL_DARK;

  logic [31:0] i;
  assign i = 32'(idx_i);

  always_comb begin
    if (i < 32'(E_DARK0))       region_o = RGN_BLANK;
    else if (i < 32'(E_ACT))    region_o = RGN_DARK;
    else if (i < 32'(E_DARK1))  region_o = RGN_ACTIVE;
    else if (i < 32'(E_BLANK1)) region_o = RGN_DARK;
    else                        region_o = RGN_BLANK;
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer import lct_pkg::*; #(
  parameter int TPE        = 8,
  parameter int XFER       = 8,
  parameter int LEN_W      = 16,
  parameter int DT_W       = 3,
  parameter int LEAD_BLANK = 4,
  parameter int LEAD_DARK  = 12,
  parameter int ACTIVE     = 2098,
  parameter int TRAIL_DARK = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             tg1_o,
  output logic             tg2_o,
  output logic             rst_pulse_o,
  output logic             clamp_o,
  output logic             sample_o,
  output logic             line_start_o,
  output logic [1:0]       region_o
);
  localparam int HALF = TPE / 2;
  localparam int TW   = $clog2(TPE);

  logic [TW-1:0]    tick;
  logic             elem_last, run, xfer;
  logic [LEN_W-1:0] elem, rd_idx;
  logic [DT_W-1:0]  dead;
  region_e          rgn_map, rgn_q, rgn_nxt;
  logic p1_n, p2_n, g1_n, g2_n, rp_n, cl_n, sm_n, ls_n;

  lct_tick_gen #(.TPE(TPE), .TW(TW)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .last_o(elem_last)
  );

  lct_line_seq #(.LEN_W(LEN_W), .XFER(XFER), .DT_W(DT_W), .HALF(HALF)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .elem_last_i(elem_last),
    .len_i(line_len_i), .dead_i(dead_i), .run_o(run), .elem_o(elem),
    .xfer_o(xfer), .rd_idx_o(rd_idx), .dead_o(dead)
  );

  lct_region_map #(
    .LEN_W(LEN_W), .LEAD_BLANK(LEAD_BLANK), .LEAD_DARK(LEAD_DARK),
    .ACTIVE(ACTIVE), .TRAIL_DARK(TRAIL_DARK)
  ) u_map (
    .idx_i(rd_idx), .region_o(rgn_map)
  );

  always_comb begin
    p1_n = 1'b0; p2_n = 1'b0; g1_n = 1'b0; g2_n = 1'b0;
    rp_n = 1'b0; cl_n = 1'b0; sm_n = 1'b0; ls_n = 1'b0;
    rgn_nxt = rgn_q;
    if (run) begin
      if (xfer) begin
        // phases parked: phase 1 high, phase 2 low
        p1_n = 1'b1;
        g1_n = (elem < LEN_W'(XFER - 2));
        g2_n = (elem < LEN_W'(XFER - 1));
      end else begin
        p2_n = (int'(tick) >= int'(dead)) && (int'(tick) < HALF);
        p1_n = (int'(tick) >= HALF + int'(dead));
        rp_n = (int'(tick) == 0);
        cl_n = (int'(tick) == HALF);
        sm_n = (int'(tick) == TPE - 1);
        if (sm_n) begin
          rgn_nxt = rgn_map;
          ls_n    = (rd_idx == '0);
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phi1_o <= 1'b0; phi2_o <= 1'b0; tg1_o <= 1'b0; tg2_o <= 1'b0;
      rst_pulse_o <= 1'b0; clamp_o <= 1'b0; sample_o <= 1'b0;
      line_start_o <= 1'b0; rgn_q <= RGN_BLANK;
    end else begin
      phi1_o <= p1_n; phi2_o <= p2_n; tg1_o <= g1_n; tg2_o <= g2_n;
      rst_pulse_o <= rp_n; clamp_o <= cl_n; sample_o <= sm_n;
      line_start_o <= ls_n; rgn_q <= rgn_nxt;
    end
  end

  assign region_o = rgn_q;
endmodule

// File: rtl/lct_checks.sv
module lct_checks (
  input logic clk_i,
  input logic rst_ni,
  input logic phi1_o,
  input logic phi2_o,
  input logic tg1_o,
  input logic tg2_o,
  input logic rst_pulse_o,
  input logic clamp_o,
  input logic sample_o,
  input logic line_start_o
);
  // R6
  phase_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi1_o && phi2_o));

  // R3
  gate_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg1_o |-> tg2_o);

  // R3
  gate_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tg1_o) |-> tg2_o);

  // R4
  park_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg2_o |-> (phi1_o && !phi2_o));

  // R8
  reset_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |=> !rst_pulse_o);

  // R8
  clamp_after_ph2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> ($past(phi2_o) && !phi2_o));

  // R11
  start_with_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> sample_o);
endmodule

bind ccd_line_timer lct_checks u_lct_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .phi1_o(phi1_o), .phi2_o(phi2_o),
  .tg1_o(tg1_o), .tg2_o(tg2_o), .rst_pulse_o(rst_pulse_o),
  .clamp_o(clamp_o), .sample_o(sample_o), .line_start_o(line_start_o)
);

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;
  localparam int TPE  = 8;
  localparam int HALF = TPE / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] len = 16'd40;
  logic [2:0]  dead = 3'd1;
  logic ph1, ph2, tg1, tg2, rp, cl, sm, ls;
  logic [1:0] rgn;

  int nchk = 0;
  int nerr = 0;
  bit timeout = 1'b0;

  always #4 clk = ~clk;

  ccd_line_timer i_ccd_line_timer (
    .clk_i(clk), .rst_ni(rst_n), .line_len_i(len), .dead_i(dead),
    .phi1_o(ph1), .phi2_o(ph2), .tg1_o(tg1), .tg2_o(tg2),
    .rst_pulse_o(rp), .clamp_o(cl), .sample_o(sm), .line_start_o(ls),
    .region_o(rgn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return ph1;
      1: return ph2;
      2: return tg1;
      3: return tg2;
      default: return rp;
    endcase
  endfunction

  // counts negedges until selected signal equals val
  task automatic cnt_until(input int sel, input logic val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(sel) !== val && n < 40000);
  endtask

  task automatic wait_tg1_rise();
    logic p;
    p = tg1;
    forever begin
      @(negedge clk);
      if (tg1 && !p) return;
      p = tg1;
    end
  endtask

  // called right at a tg1 rise; returns ticks to the next rise
  task automatic measure_line(output int n);
    logic p;
    p = tg1;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if ((tg1 && !p) || n > 40000) return;
      p = tg1;
    end
  endtask

  task automatic t_reset();
    int bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (ph1 | ph2 | tg1 | tg2 | rp | cl | sm | ls | (rgn != 2'd0)) bad++;
    end
    rst_n = 1'b1;
    @(negedge clk);
    if (ph1 | ph2 | tg1 | tg2 | rp | cl | sm | ls | (rgn != 2'd0)) bad++;
    chk(bad == 0, "R1 outputs idle in reset", bad, 0);
  endtask

  task automatic t_transfer();
    int f1 = -1, f2 = -1, r1 = -1, bad = 0;
    len = 16'd40; dead = 3'd1;
    wait_tg1_rise();
    if (!(ph1 && !ph2 && tg2)) bad++;
    for (int t = 1; t <= 80; t++) begin
      @(negedge clk);
      if (f1 < 0 && !tg1) f1 = t;
      if (f2 < 0 && !tg2) f2 = t;
      if (r1 < 0 && rp) r1 = t;
      if (tg2 && !(ph1 && !ph2)) bad++;
    end
    chk(f1 == 6 * TPE, "R3 gate1 width", f1, 6 * TPE);
    chk(f2 - f1 == TPE, "R3 gate2 after gate1", f2 - f1, TPE);
    chk(r1 - f2 == TPE, "R3 readout after gate2", r1 - f2, TPE);
    chk(bad == 0, "R4 phases parked in transfer", bad, 0);
  endtask

  task automatic t_period(input int l, input int exp_el);
    int n;
    len = 16'(l);
    wait_tg1_rise();
    measure_line(n);
    chk(n == exp_el * TPE, "R2 line period", n, exp_el * TPE);
  endtask

  task automatic t_midline();
    int n1, n2;
    len = 16'd40;
    wait_tg1_rise();
    wait_tg1_rise();
    repeat (20) @(negedge clk);
    len = 16'd60;
    measure_line(n1);
    chk(n1 + 20 == 40 * TPE, "R5 current line unchanged", n1 + 20, 40 * TPE);
    measure_line(n2);
    chk(n2 == 60 * TPE, "R5 next line uses new length", n2, 60 * TPE);
  endtask

  task automatic t_phases(input logic [2:0] d, input int d_eff);
    int n, w2, gap, w1;
    dead = d; len = 16'd40;
    wait_tg1_rise();
    wait_tg1_rise();
    cnt_until(3, 1'b0, n);
    cnt_until(1, 1'b1, n);
    cnt_until(1, 1'b0, w2);
    cnt_until(0, 1'b1, gap);
    cnt_until(0, 1'b0, w1);
    chk(w2 == HALF - d_eff, "R6 phase2 width", w2, HALF - d_eff);
    chk(gap == d_eff, "R6 dead gap", gap, d_eff);
    chk(w1 == HALF - d_eff, "R6 phase1 width", w1, HALF - d_eff);
    if (d == 3'd0 || d > 3'(HALF - 1))
      chk(w2 == HALF - d_eff, "R7 dead time clamp", w2, HALF - d_eff);
  endtask

  task automatic t_cds();
    int n, nr = 0, ncl = 0, bad = 0;
    logic psm, pph2, prp;
    dead = 3'd1; len = 16'd40;
    wait_tg1_rise();
    cnt_until(3, 1'b0, n);
    repeat (12) @(negedge clk);
    psm = sm; pph2 = ph2; prp = rp;
    for (int t = 0; t < 3 * TPE; t++) begin
      @(negedge clk);
      if (rp) begin nr++; if (!psm) bad++; end
      if (prp && rp) bad++;
      if (cl) begin ncl++; if (!(pph2 && !ph2)) bad++; end
      psm = sm; pph2 = ph2; prp = rp;
    end
    chk(nr == 3, "R8 reset pulses per element", nr, 3);
    chk(ncl == 3, "R8 clamp strobes per element", ncl, 3);
    chk(bad == 0, "R8 strobe placement", bad, 0);
  endtask

  task automatic t_regions(input int l, input int eb, input int ed, input int ea);
    int nb = 0, nd = 0, na = 0, nx = 0, idx = 0, fd = -1, falls = 0, fd_falls = -1;
    int nls = 0, ls_bad = 0, n = 0;
    logic p2, pt;
    len = 16'(l); dead = 3'd1;
    wait_tg1_rise();
    wait_tg1_rise();
    p2 = ph2; pt = tg1;
    forever begin
      @(negedge clk);
      n++;
      if (tg1 && !pt) break;
      if (n > 40000) break;
      pt = tg1;
      if (p2 && !ph2) falls++;
      p2 = ph2;
      if (ls) begin nls++; if (!(sm && idx == 0)) ls_bad++; end
      if (sm) begin
        case (rgn)
          2'd0: nb++;
          2'd1: begin nd++; if (fd < 0) begin fd = idx; fd_falls = falls; end end
          2'd2: na++;
          default: nx++;
        endcase
        idx++;
      end
    end
    chk(nb == eb, "R9 blank count", nb, eb);
    chk(nd == ed, "R9 dark count", nd, ed);
    chk(na == ea, "R9 active count", na, ea);
    chk(nx == 0, "R9 no illegal code", nx, 0);
    chk(fd == 4, "R9 first dark index", fd, 4);
    chk(fd_falls == 5, "R10 first dark after fifth phase2 fall", fd_falls, 5);
    chk(nls == 1 && ls_bad == 0, "R11 single line start on first sample", nls, 1);
  endtask

  task automatic run_all();
    t_reset();
    t_transfer();
    t_period(40, 40);
    t_period(3, 9);
    t_period(100, 100);
    t_midline();
    t_phases(3'd1, 1);
    t_phases(3'd3, 3);
    t_phases(3'd0, 1);
    t_phases(3'd7, 3);
    t_cds();
    t_regions(100, 4, 12, 76);
    t_regions(2144, 14, 24, 2098);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual 1 expected 0");
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule